// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Event Interrupts

This block controls a bank of general-purpose pins through a plain 32-bit register port. Software sets, for each pin, whether the input is visible, whether the pad is driven, the value to drive, and an inversion mask applied to that value on its way to the pad. Pad inputs cross into the clock domain through a two-stage synchronizer before any logic sees them.

Each pin watches for four kinds of event: a rising edge, a falling edge, a high level and a low level. Each event kind has its own pending register and its own enable register. A pending bit records that its event happened and stays set until software writes a one to that bit. Every pin has its own interrupt line. The line is high while any of the four event kinds has both its pending bit and its enable bit set for that pin. The register port has no handshake: a write takes effect at the clock edge where `reg_wr_en` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is asserted, every readable register reads zero, and `pad_oe`, `pad_out` and `irq` are all zero.
- R2: `pad_oe` equals the drive-enable register (offset 0x08). `pad_out` equals (out-value at 0x0C XOR invert mask at 0x40) AND the drive-enable register. Registers written at 0x08, 0x0C and 0x40 read back unchanged.
- R3: The sampled-input register (offset 0x00) reads the synchronized pad level ANDed with the input-enable register (0x04). A pad change made before clock edge k is visible after edge k+1.
- R4: The rising-edge pending register (0x1C) and the falling-edge pending register (0x24) set the bit of a pin whose pad changes in that direction. A pad change made before edge k is set in the register after edge k+2 and is not set after edge k+1.
- R5: The high-level pending register (0x2C) and the low-level pending register (0x34) set a pin's bit on every cycle in which the synchronized pad holds that level.
- R6: Writing a 1 to a bit of a pending register clears that bit. Writing a 0 leaves the bit unchanged. Once set, a pending bit stays set until such a clear.
- R7: When a set condition and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R8: `irq[i]` is the OR, over the four event kinds, of (pending AND enable) for pin i. The enable registers are rise 0x18, fall 0x20, high 0x28 and low 0x30.
- R9: With all four enable registers at zero, no `irq` line is asserted, whatever is pending.
- R10: Reads of any offset not listed in R2 to R8, misaligned offsets included, return zero. Writes to the sampled-input register (0x00) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, upper bits zero |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Level driven to each pad |
| pad_oe | output | NPINS | Pad drive enable |
| irq | output | NPINS | Per-pin interrupt lines |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a set condition on the same pending bit. From the ports, the only source of a condition that repeats every cycle is a level, so the bench holds a pad high long enough for the high-level bit to be set. It then writes a one to that bit and reads the register back: the bit must still be set. A neighbouring edge bit, whose condition has gone away, must clear under the same kind of write. The edge latency is pinned by reading the edge pending register one cycle before and one cycle after the expected set edge.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NTRIG = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // Event-kind index within the pending and enable arrays
  localparam int TRG_RISE = 0;
  localparam int TRG_FALL = 1;
  localparam int TRG_HIGH = 2;
  localparam int TRG_LOW  = 3;

  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN_EN  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DRV_EN = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_OUTVAL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_INVERT = 8'h40;

  // Event enable and pending registers are interleaved on an 8-byte pitch
  function automatic logic [ADDR_W-1:0] evt_en_ofs(input int t);
    return ADDR_W'(8'h18 + 8 * t);
  endfunction

  function automatic logic [ADDR_W-1:0] evt_pend_ofs(input int t);
    return ADDR_W'(8'h1C + 8 * t);
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rose,
  output logic [W-1:0] dropped
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;
  logic [W-1:0] prior_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
      prior_q  <= '0;
    end else begin
      meta_q   <= raw_in;
      stable_q <= meta_q;
      prior_q  <= stable_q;
    end
  end

  assign level   = stable_q;
  assign rose    = stable_q & ~prior_q;
  assign dropped = ~stable_q & prior_q;
endmodule

// File: rtl/pinbank_pend.sv
module pinbank_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  irq
);
  localparam int W = NPINS;

  logic [W-1:0] wval;
  logic [W-1:0] in_en_q, drv_en_q, outval_q, invert_q;
  logic [NTRIG-1:0][W-1:0] en_q;
  logic [NTRIG-1:0][W-1:0] pend_q;
  logic [NTRIG-1:0][W-1:0] cond;
  logic [W-1:0] lvl, rose, dropped;

  assign wval = reg_wdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en_q  <= '0;
      drv_en_q <= '0;
      outval_q <= '0;
      invert_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == OFS_IN_EN)  in_en_q  <= wval;
      if (reg_addr == OFS_DRV_EN) drv_en_q <= wval;
      if (reg_addr == OFS_OUTVAL) outval_q <= wval;
      if (reg_addr == OFS_INVERT) invert_q <= wval;
    end
  end

  pinbank_sync #(.W(W)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_in(pad_in),
    .level(lvl), .rose(rose), .dropped(dropped)
  );

  assign cond[TRG_RISE] = rose;
  assign cond[TRG_FALL] = dropped;
  assign cond[TRG_HIGH] = lvl;
  assign cond[TRG_LOW]  = ~lvl;

  for (genvar t = 0; t < NTRIG; t++) begin : g_evt
    logic [W-1:0] clr;
    assign clr = (reg_wr_en && reg_addr == evt_pend_ofs(t)) ? wval : '0;

    pinbank_pend #(.W(W)) pend_i (
      .clk(clk), .rst_n(rst_n), .set_mask(cond[t]),
      .clr_mask(clr), .flags(pend_q[t])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[t] <= '0;
      else if (reg_wr_en && reg_addr == evt_en_ofs(t)) en_q[t] <= wval;
    end
  end

  always_comb begin
    irq = '0;
    for (int t = 0; t < NTRIG; t++) irq = irq | (pend_q[t] & en_q[t]);
  end

  assign pad_oe  = drv_en_q;
  assign pad_out = (outval_q ^ invert_q) & drv_en_q;

  always_comb begin
    logic [W-1:0] sel;
    sel = '0;
    case (reg_addr)
      OFS_SAMPLE: sel = lvl & in_en_q;
      OFS_IN_EN:  sel = in_en_q;
      OFS_DRV_EN: sel = drv_en_q;
      OFS_OUTVAL: sel = outval_q;
      OFS_INVERT: sel = invert_q;
      default: begin
        for (int t = 0; t < NTRIG; t++) begin
          if (reg_addr == evt_en_ofs(t))   sel = en_q[t];
          if (reg_addr == evt_pend_ofs(t)) sel = pend_q[t];
        end
      end
    endcase
    reg_rdata = DATA_W'(sel);
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr_en,
  input logic [7:0]              reg_addr,
  input logic [31:0]             reg_rdata,
  input logic [NPINS-1:0]        pad_out,
  input logic [NPINS-1:0]        pad_oe,
  input logic [NPINS-1:0]        irq,
  input logic [NPINS-1:0]        in_en_q,
  input logic [NTRIG-1:0][NPINS-1:0] en_q,
  input logic [NTRIG-1:0][NPINS-1:0] pend_q
);
  // R2
  pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R3
  sample_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_SAMPLE) |-> ((reg_rdata[NPINS-1:0] & ~in_en_q) == '0));

  // R6
  rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(pend_q[TRG_RISE]) & ~pend_q[TRG_RISE]) != '0)) |->
      ($past(reg_wr_en) && $past(reg_addr) == evt_pend_ofs(TRG_RISE)));

  // R6
  high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(pend_q[TRG_HIGH]) & ~pend_q[TRG_HIGH]) != '0)) |->
      ($past(reg_wr_en) && $past(reg_addr) == evt_pend_ofs(TRG_HIGH)));

  // R9
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq == '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00 || reg_addr == 8'h10 || reg_addr == 8'h14 ||
     reg_addr == 8'h38 || reg_addr == 8'h3C || reg_addr > 8'h40)
      |-> (reg_rdata == '0));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .in_en_q(in_en_q), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/pinbank_ctrl_tb_top.sv
module pinbank_ctrl_tb_top;
  localparam int N = 4;
  localparam int M = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pinbank_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all_pend();
    for (int t = 0; t < 4; t++) wr(8'h1C + 8'(8 * t), 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] v;
    // R1: reset state, read while reset is held
    #1;
    for (int a = 0; a < 'h48; a += 4) begin
      rd(8'(a), v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset pad_oe", 32'(pad_oe), 0);
    check("R1 reset pad_out", 32'(pad_out), 0);
    check("R1 reset irq", 32'(irq), 0);
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(2);

    // R2: exhaustive pad drive sweep
    for (int oe = 0; oe <= M; oe++) begin
      wr(8'h08, 32'(oe));
      for (int ov = 0; ov <= M; ov++) begin
        wr(8'h0C, 32'(ov));
        for (int iv = 0; iv <= M; iv++) begin
          wr(8'h40, 32'(iv));
          check("R2 pad_out", 32'(pad_out), 32'((ov ^ iv) & oe));
          check("R2 pad_oe", 32'(pad_oe), 32'(oe));
        end
        rd(8'h0C, v); check("R2 outval readback", v, 32'(ov));
      end
      rd(8'h08, v); check("R2 drive-enable readback", v, 32'(oe));
    end
    rd(8'h40, v); check("R2 invert readback", v, 32'(M));
    wr(8'h08, 0);

    // R3: input sampling against input enable, with latency
    for (int ie = 0; ie <= M; ie++) begin
      for (int p = 0; p <= M; p++) begin
        pad_in = N'(p);
        wr(8'h04, 32'(ie));           // two clock edges pass
        rd(8'h00, v); check("R3 sample", v, 32'(p & ie));
      end
    end
    wr(8'h04, 32'(M));
    pad_in = '0;
    wait_neg(3);
    @(negedge clk); pad_in = 4'b0101;
    wait_neg(1); rd(8'h00, v); check("R3 not yet visible", v, 0);
    wait_neg(1); rd(8'h00, v); check("R3 visible after second edge", v, 32'h5);

    // R10: sampled-input register is read-only
    wr(8'h04, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R10 sample write ignored", v, 0);
    wr(8'h04, 32'(M));
    rd(8'h00, v); check("R10 sample still reflects pad", v, 32'h5);

    // R4, R5: per-pin edge and level detection with exact latency
    pad_in = '0;
    wait_neg(4);
    for (int p = 0; p < N; p++) begin
      clear_all_pend();
      pad_in[p] = 1'b1;
      wait_neg(2);
      rd(8'h1C, v); check("R4 rise not before third edge", v, 0);
      wait_neg(1);
      rd(8'h1C, v); check("R4 rise pending", v, 32'(1 << p));
      rd(8'h2C, v); check("R5 high pending", v, 32'(1 << p));
      rd(8'h24, v); check("R4 no fall yet", v, 0);
      pad_in[p] = 1'b0;
      wait_neg(2);
      rd(8'h24, v); check("R4 fall not before third edge", v, 0);
      wait_neg(1);
      rd(8'h24, v); check("R4 fall pending", v, 32'(1 << p));
      rd(8'h34, v); check("R5 low pending all pins", v, 32'(M));
      wait_neg(2);
    end

    // R6, R7: clear semantics while a pad level holds
    clear_all_pend();
    pad_in = 4'b0011;
    wait_neg(4);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R6 write zero keeps", v, 32'h3);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R6 write one clears", v, 32'h2);
    wr(8'h2C, 32'h3);
    rd(8'h2C, v); check("R7 set beats clear", v, 32'h3);
    wr(8'h34, 32'hF);
    rd(8'h34, v); check("R7 low set beats clear on low pins", v, 32'hC);
    wait_neg(5);
    rd(8'h1C, v); check("R6 stays without new edge", v, 32'h2);

    // R8: interrupt combining, swept per event kind
    pad_in = '0; wait_neg(4); clear_all_pend();
    pad_in = 4'hF; wait_neg(4);
    wr(8'h24, 32'hF); wr(8'h34, 32'hF);
    for (int t = 0; t < 4; t++) begin
      for (int e = 0; e <= M; e++) begin
        wr(8'h18 + 8'(8 * t), 32'(e));
        // rise and high pending all set, fall and low clear
        check("R8 irq", 32'(irq), (t == 0 || t == 2) ? 32'(e) : 0);
        rd(8'h18 + 8'(8 * t), v); check("R8 enable readback", v, 32'(e));
      end
      wr(8'h18 + 8'(8 * t), 0);
    end
    wr(8'h18, 32'h1); wr(8'h28, 32'h4);
    check("R8 irq two kinds", 32'(irq), 32'h5);

    // R9: all enables zero silences irq
    wr(8'h18, 0); wr(8'h28, 0);
    pad_in = 4'h0; wait_neg(4);
    check("R9 irq quiet", 32'(irq), 0);

    // R10: unmapped and misaligned offsets read zero
    for (int a = 0; a < 256; a++) begin
      if (!((a % 4 == 0) && (a <= 'h0C || (a >= 'h18 && a <= 'h34) || a == 'h40))) begin
        rd(8'(a), v); check("R10 unmapped", v, 0);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule